// File: doc/BRIEF.md
# Hardware Call and Data Stack

This block is a small on-chip last-in-first-out store that serves two purposes at once. It holds data words for a processor, and it holds the return linkage for subroutine calls and interrupt returns. Each cycle it can take one operation, given as a 3-bit code with a valid strobe. Data operations move 32-bit words between a register value and the stack: push, pop, discard and a non-destructive read of the top. Flow operations compute or restore a program counter: call, relative jump, return and return-from-interrupt.

Relative targets are formed from the current program counter and a 16-bit unsigned magnitude. A separate direction bit chooses a forward or a backward offset. A call saves the address after the current one before it redirects. A return takes its target from the top entry. A return-from-interrupt also removes a status word stored below the return address and presents it for the flags to be restored. An operation that would overrun or underrun the storage is refused, and it sets a sticky error flag. All results appear one clock after the operation is accepted.

Top module: `linkstk`

## Requirements
- R1: After reset, empty is 1, full is 0, err is 0, and redirect, data_vld and status_vld are 0.
- R2: Op codes: 0 push, 1 pop, 2 discard, 3 fetch, 4 call, 5 jump, 6 return, 7 return-from-interrupt. While op_valid is 0, op_code has no effect: redirect, data_vld and status_vld stay 0 in the next cycle and the stack contents are kept.
- R3: Push stores wr_data. Pop removes the top entry, which appears on top_data with data_vld high one cycle after the op. Entries come back in reverse order of pushing.
- R4: full is 1 exactly when DEPTH entries are held. A push or call while full sets err, writes nothing and does not redirect.
- R5: A pop, discard, fetch or return while empty sets err. It produces no data_vld and no redirect, and the stack stays empty.
- R6: Fetch presents the top entry with data_vld and leaves the depth unchanged, so a following pop returns the same word.
- R7: Discard removes the top entry without raising data_vld. A following pop returns the entry that was below it.
- R8: A call pushes pc_in+1 and, one cycle later, raises redirect for one cycle with next_pc = pc_in+ofs_mag when ofs_back is 0, or pc_in-ofs_mag when ofs_back is 1. The result wraps modulo 2^32.
- R9: A jump redirects to the same target as a call but leaves the stack contents and depth unchanged.
- R10: A return pops the top entry and redirects to it.
- R11: A return-from-interrupt pops two entries. It redirects to the top one and presents the one below it on status_word with status_vld high. With fewer than two entries it is an error and leaves the stack unchanged.
- R12: err stays 1 from its first error until reset, and an erroneous op changes no stored entry and no depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (see R2) |
| wr_data | input | 32 | Word to push |
| pc_in | input | 32 | Current program counter |
| ofs_mag | input | 16 | Offset magnitude for call and jump |
| ofs_back | input | 1 | 1 selects a backward offset |
| top_data | output | 32 | Word read by pop or fetch |
| data_vld | output | 1 | top_data valid for one cycle |
| next_pc | output | 32 | Redirect target |
| redirect | output | 1 | next_pc valid for one cycle |
| status_word | output | 32 | Status word restored by return-from-interrupt |
| status_vld | output | 1 | status_word valid for one cycle |
| full | output | 1 | Stack holds DEPTH entries |
| empty | output | 1 | Stack holds no entries |
| err | output | 1 | Sticky overrun or underrun flag |

## Verification
The bench builds the block with DEPTH set to 4 rather than the default 16. This makes the full boundary reachable after four pushes, so the bench can check the refused push and the refused call, and then drain the stack to show that nothing was overwritten. The 32-bit data width is kept, so the wrap of a backward offset below address zero and a maximum forward magnitude are exercised at their real width. With only four slots, a return-from-interrupt on a single entry can be checked as an underrun in a short run.

// File: rtl/linkstk_pkg.sv
package linkstk_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 16;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_DISC  = 3'd2,
    OP_FETCH = 3'd3,
    OP_CALL  = 3'd4,
    OP_JUMP  = 3'd5,
    OP_RET   = 3'd6,
    OP_RETI  = 3'd7
  } stk_op_e;
endpackage

// File: rtl/linkstk_ram.sv
module linkstk_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re_a,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic             re_b,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read ports with enables; outputs hold between reads.
  always_ff @(posedge clk) begin
    if (re_a) rdata_a <= mem[raddr_a];
  end

  always_ff @(posedge clk) begin
    if (re_b) rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/linkstk_target.sv
module linkstk_target #(
  parameter int WIDTH = 32,
  parameter int OW    = 16
) (
  input  logic [WIDTH-1:0] pc,
  input  logic [OW-1:0]    mag,
  input  logic             back,
  output logic [WIDTH-1:0] target,
  output logic [WIDTH-1:0] ret_addr
);
  localparam int PAD = WIDTH - OW;
  logic [WIDTH-1:0] mag_ext;

  always_comb begin
    mag_ext  = {{PAD{1'b0}}, mag};
    target   = back ? (pc - mag_ext) : (pc + mag_ext);
    ret_addr = pc + {{(WIDTH-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/linkstk_ctrl.sv
module linkstk_ctrl
  import linkstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  stk_op_e       op,
  output logic          we,
  output logic          wsel_ret,
  output logic [AW-1:0] waddr,
  output logic          re_a,
  output logic [AW-1:0] raddr_a,
  output logic          re_b,
  output logic [AW-1:0] raddr_b,
  output logic          load_tgt,
  output logic          data_vld,
  output logic          redirect,
  output logic          from_stack,
  output logic          status_vld,
  output logic          full,
  output logic          empty,
  output logic          err
);
  logic [CW-1:0] depth_q, depth_d;
  logic          room, have1, have2, bad, acc;

  always_comb begin
    room  = depth_q != CW'(DEPTH);
    have1 = depth_q != '0;
    have2 = depth_q >= CW'(2);
    unique case (op)
      OP_PUSH, OP_CALL:                bad = !room;
      OP_POP, OP_DISC, OP_FETCH, OP_RET: bad = !have1;
      OP_RETI:                         bad = !have2;
      default:                         bad = 1'b0;
    endcase
    acc      = op_valid && !bad;
    we       = acc && (op == OP_PUSH || op == OP_CALL);
    wsel_ret = op == OP_CALL;
    waddr    = AW'(depth_q);
    re_a     = acc && (op == OP_POP || op == OP_FETCH || op == OP_RET || op == OP_RETI);
    raddr_a  = AW'(depth_q - CW'(1));
    re_b     = acc && (op == OP_RETI);
    raddr_b  = AW'(depth_q - CW'(2));
    load_tgt = acc && (op == OP_CALL || op == OP_JUMP);
    depth_d  = depth_q;
    if (acc) begin
      unique case (op)
        OP_PUSH, OP_CALL:        depth_d = depth_q + CW'(1);
        OP_POP, OP_DISC, OP_RET: depth_d = depth_q - CW'(1);
        OP_RETI:                 depth_d = depth_q - CW'(2);
        default:                 depth_d = depth_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q    <= '0;
      data_vld   <= 1'b0;
      redirect   <= 1'b0;
      from_stack <= 1'b0;
      status_vld <= 1'b0;
      err        <= 1'b0;
    end else begin
      depth_q    <= depth_d;
      data_vld   <= acc && (op == OP_POP || op == OP_FETCH);
      redirect   <= acc && (op == OP_CALL || op == OP_JUMP || op == OP_RET || op == OP_RETI);
      if (acc && (op == OP_RET || op == OP_RETI)) from_stack <= 1'b1;
      else if (load_tgt)                          from_stack <= 1'b0;
      status_vld <= acc && (op == OP_RETI);
      err        <= err || (op_valid && bad);
    end
  end

  assign full  = depth_q == CW'(DEPTH);
  assign empty = depth_q == '0;
endmodule

// File: rtl/linkstk.sv
module linkstk
  import linkstk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [OFS_W-1:0]  ofs_mag,
  input  logic              ofs_back,
  output logic [WORD_W-1:0] top_data,
  output logic              data_vld,
  output logic [WORD_W-1:0] next_pc,
  output logic              redirect,
  output logic [WORD_W-1:0] status_word,
  output logic              status_vld,
  output logic              full,
  output logic              empty,
  output logic              err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic              we, wsel_ret, re_a, re_b, load_tgt, from_stack;
  logic [AW-1:0]     waddr, raddr_a, raddr_b;
  logic [WORD_W-1:0] wdata, tgt, ret_addr, tgt_q, rd_a;

  linkstk_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(stk_op_e'(op_code)),
    .we(we), .wsel_ret(wsel_ret), .waddr(waddr),
    .re_a(re_a), .raddr_a(raddr_a), .re_b(re_b), .raddr_b(raddr_b),
    .load_tgt(load_tgt), .data_vld(data_vld), .redirect(redirect),
    .from_stack(from_stack), .status_vld(status_vld),
    .full(full), .empty(empty), .err(err)
  );

  linkstk_target #(.WIDTH(WORD_W), .OW(OFS_W)) u_tgt (
    .pc(pc_in), .mag(ofs_mag), .back(ofs_back),
    .target(tgt), .ret_addr(ret_addr)
  );

  assign wdata = wsel_ret ? ret_addr : wr_data;

  linkstk_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re_a(re_a), .raddr_a(raddr_a), .rdata_a(rd_a),
    .re_b(re_b), .raddr_b(raddr_b), .rdata_b(status_word)
  );

  always_ff @(posedge clk) begin
    if (rst)           tgt_q <= '0;
    else if (load_tgt) tgt_q <= tgt;
  end

  assign top_data = rd_a;
  assign next_pc  = from_stack ? rd_a : tgt_q;
endmodule

// File: rtl/linkstk_chk.sv
module linkstk_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [31:0] pc_in,
  input logic [15:0] ofs_mag,
  input logic        ofs_back,
  input logic [31:0] next_pc,
  input logic        redirect,
  input logic        data_vld,
  input logic        status_vld,
  input logic        full,
  input logic        empty,
  input logic        err
);
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !redirect && !data_vld && !status_vld);

  p_full_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    full && op_valid && (op_code == 3'd0 || op_code == 3'd4) |=> full && err && !redirect);

  p_empty_refuse_r5: assert property (@(posedge clk) disable iff (rst)
    empty && op_valid && (op_code == 3'd1 || op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd6)
    |=> empty && err && !data_vld && !redirect);

  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_jump_target_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == 3'd5 |=> redirect && $stable(full) && $stable(empty) &&
    next_pc == ($past(ofs_back) ? $past(pc_in) - {16'd0, $past(ofs_mag)}
                                : $past(pc_in) + {16'd0, $past(ofs_mag)}));
endmodule

bind linkstk linkstk_chk i_chk (.*);

// File: tb/test_linkstk.sv
`timescale 1ns/1ps
module test_linkstk;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] wr_data, pc_in;
  logic [15:0] ofs_mag;
  logic        ofs_back;
  logic [31:0] top_data, next_pc, status_word;
  logic        data_vld, redirect, status_vld, full, empty, err;
  int checks = 0;
  int fails  = 0;

  localparam logic [2:0] PUSH = 3'd0, POP = 3'd1, DISC = 3'd2, FETCH = 3'd3,
                         CALL = 3'd4, JUMP = 3'd5, RET = 3'd6, RETI = 3'd7;

  always #2 clk = ~clk;

  linkstk #(.DEPTH(4)) i_linkstk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .wr_data(wr_data), .pc_in(pc_in), .ofs_mag(ofs_mag), .ofs_back(ofs_back),
    .top_data(top_data), .data_vld(data_vld), .next_pc(next_pc),
    .redirect(redirect), .status_word(status_word), .status_vld(status_vld),
    .full(full), .empty(empty), .err(err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; op_code = '0; wr_data = '0;
    pc_in = '0; ofs_mag = '0; ofs_back = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drives one op for one cycle; returns at the next falling edge, after
  // the registered results of that op have appeared.
  task automatic run_op(input logic [2:0] op, input logic [31:0] d,
                        input logic [31:0] pc, input logic [15:0] mag,
                        input logic back);
    op_valid = 1'b1; op_code = op; wr_data = d; pc_in = pc;
    ofs_mag = mag; ofs_back = back;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [31:0] exp);
    run_op(POP, '0, '0, '0, 1'b0);
    check(req, "pop valid", {31'd0, data_vld}, 32'd1);
    check(req, "pop data", top_data, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "empty", {31'd0, empty}, 32'd1);
    check("R1", "full", {31'd0, full}, 32'd0);
    check("R1", "err", {31'd0, err}, 32'd0);
    check("R1", "pulses", {29'd0, redirect, data_vld, status_vld}, 32'd0);
  endtask

  task automatic t_lifo();
    do_reset();
    run_op(PUSH, 32'hA0A0_0001, '0, '0, 1'b0);
    run_op(PUSH, 32'hB0B0_0002, '0, '0, 1'b0);
    run_op(PUSH, 32'hC0C0_0003, '0, '0, 1'b0);
    pop_expect("R3", 32'hC0C0_0003);
    pop_expect("R3", 32'hB0B0_0002);
    pop_expect("R3", 32'hA0A0_0001);
    check("R3", "empty after drain", {31'd0, empty}, 32'd1);
    check("R3", "no err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 4; i++) run_op(PUSH, 32'h100 + i, '0, '0, 1'b0);
    check("R4", "full at depth", {31'd0, full}, 32'd1);
    check("R4", "no err yet", {31'd0, err}, 32'd0);
    run_op(PUSH, 32'hDEAD_BEEF, '0, '0, 1'b0);
    check("R4", "err on push full", {31'd0, err}, 32'd1);
    run_op(CALL, '0, 32'h50, 16'h8, 1'b0);
    check("R4", "no redirect on full call", {31'd0, redirect}, 32'd0);
    for (int i = 3; i >= 0; i--) pop_expect("R12", 32'h100 + i);
    check("R12", "err sticky", {31'd0, err}, 32'd1);
    check("R4", "empty after drain", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_empty();
    do_reset();
    run_op(POP, '0, '0, '0, 1'b0);
    check("R5", "pop empty err", {31'd0, err}, 32'd1);
    check("R5", "pop empty no data", {31'd0, data_vld}, 32'd0);
    do_reset();
    run_op(DISC, '0, '0, '0, 1'b0);
    check("R5", "discard empty err", {31'd0, err}, 32'd1);
    do_reset();
    run_op(FETCH, '0, '0, '0, 1'b0);
    check("R5", "fetch empty", {30'd0, err, data_vld}, 32'd2);
    do_reset();
    run_op(RET, '0, '0, '0, 1'b0);
    check("R5", "ret empty", {30'd0, err, redirect}, 32'd2);
    check("R5", "still empty", {31'd0, empty}, 32'd1);
    run_op(PUSH, 32'h77, '0, '0, 1'b0);
    check("R12", "err held after good op", {31'd0, err}, 32'd1);
    pop_expect("R12", 32'h77);
    do_reset();
    check("R12", "reset clears err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_fetch();
    do_reset();
    run_op(PUSH, 32'h11, '0, '0, 1'b0);
    run_op(PUSH, 32'h22, '0, '0, 1'b0);
    run_op(FETCH, '0, '0, '0, 1'b0);
    check("R6", "fetch valid", {31'd0, data_vld}, 32'd1);
    check("R6", "fetch data", top_data, 32'h22);
    run_op(FETCH, '0, '0, '0, 1'b0);
    check("R6", "fetch again", top_data, 32'h22);
    pop_expect("R6", 32'h22);
    pop_expect("R6", 32'h11);
  endtask

  task automatic t_discard();
    do_reset();
    run_op(PUSH, 32'h5, '0, '0, 1'b0);
    run_op(PUSH, 32'h6, '0, '0, 1'b0);
    run_op(PUSH, 32'h7, '0, '0, 1'b0);
    run_op(DISC, '0, '0, '0, 1'b0);
    check("R7", "discard no data", {31'd0, data_vld}, 32'd0);
    pop_expect("R7", 32'h6);
    pop_expect("R7", 32'h5);
  endtask

  task automatic t_call();
    do_reset();
    run_op(CALL, '0, 32'h100, 16'h20, 1'b0);
    check("R8", "redirect", {31'd0, redirect}, 32'd1);
    check("R8", "forward target", next_pc, 32'h120);
    check("R8", "not empty", {31'd0, empty}, 32'd0);
    @(negedge clk);
    check("R8", "redirect one cycle", {31'd0, redirect}, 32'd0);
    run_op(CALL, '0, 32'h10, 16'h20, 1'b1);
    check("R8", "backward wrap", next_pc, 32'hFFFF_FFF0);
    pop_expect("R8", 32'h11);
    pop_expect("R8", 32'h101);
  endtask

  task automatic t_jump();
    do_reset();
    run_op(PUSH, 32'h9, '0, '0, 1'b0);
    run_op(JUMP, '0, 32'h1000, 16'hFFFF, 1'b0);
    check("R9", "redirect", {31'd0, redirect}, 32'd1);
    check("R9", "max forward", next_pc, 32'h0001_0FFF);
    run_op(JUMP, '0, 32'h1000, 16'h10, 1'b1);
    check("R9", "backward", next_pc, 32'h0FF0);
    pop_expect("R9", 32'h9);
    check("R9", "stack untouched", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_ret();
    do_reset();
    run_op(CALL, '0, 32'h40, 16'h4, 1'b0);
    run_op(RET, '0, '0, '0, 1'b0);
    check("R10", "redirect", {31'd0, redirect}, 32'd1);
    check("R10", "return target", next_pc, 32'h41);
    check("R10", "popped", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_reti();
    do_reset();
    run_op(PUSH, 32'hA5, '0, '0, 1'b0);
    run_op(PUSH, 32'h300, '0, '0, 1'b0);
    run_op(RETI, '0, '0, '0, 1'b0);
    check("R11", "redirect", {31'd0, redirect}, 32'd1);
    check("R11", "target", next_pc, 32'h300);
    check("R11", "status valid", {31'd0, status_vld}, 32'd1);
    check("R11", "status word", status_word, 32'hA5);
    check("R11", "two popped", {31'd0, empty}, 32'd1);
    do_reset();
    run_op(PUSH, 32'h33, '0, '0, 1'b0);
    run_op(RETI, '0, '0, '0, 1'b0);
    check("R11", "short reti", {29'd0, err, redirect, status_vld}, 32'd4);
    pop_expect("R11", 32'h33);
  endtask

  task automatic t_idle();
    do_reset();
    run_op(PUSH, 32'h1, '0, '0, 1'b0);
    op_valid = 1'b0; op_code = POP;
    @(negedge clk);
    check("R2", "idle pulses", {29'd0, redirect, data_vld, status_vld}, 32'd0);
    op_code = RET;
    @(negedge clk);
    check("R2", "idle ret", {31'd0, redirect}, 32'd0);
    pop_expect("R2", 32'h1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = '0; wr_data = '0;
    pc_in = '0; ofs_mag = '0; ofs_back = 1'b0;
    t_reset();
    t_lifo();
    t_full();
    t_empty();
    t_fetch();
    t_discard();
    t_call();
    t_jump();
    t_ret();
    t_reti();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule